// File: doc/BRIEF.md
# Paged DRAM Select and Remap Decoder

This block sits between the address bus of an 8-bit CPU with a 64 KB address space and a bank of multiplexed-address DRAM on the same board. It looks at the 16-bit address, the memory-request strobe, a 4-bit RAM page number and a mode bit that picks either ROM mode, where low memory belongs to ROM, or RAM-only mode. From these it decides whether the access targets on-board RAM. It also produces the two bytes that the DRAM takes one after the other: a row byte and a column byte.

A build-time parameter selects the board variant. The full variant has 64 KB of DRAM. The half-capacity variant uses 32 KB devices that work in only one half, and a second parameter fixes which half that is. In the full variant, page 1 at 8000h to BFFFh in ROM mode is steered onto DRAM locations 0000h to 3FFFh. It does this by clearing the column MSB. The row byte carries A14 in its top bit instead of A7.

The block is purely combinational, and every output follows its inputs in the same cycle. No data streams through it, so it has no valid/ready handshake. All pins are plain control and address signals.

Top module: `dram_page_decoder`

## Requirements
- R1: `ram_sel` is 0 whenever `mem_req` is 0, for every address, page and mode.
- R2: Full variant, `ram_only`=1 and `page`=0: `ram_sel` is 1 for every address while `mem_req` is 1.
- R3: Full variant, `ram_only`=0: addresses 0000h–3FFFh never select RAM, and 4000h–7FFFh select it only when `page`=0.
- R4: Full variant, `ram_only`=0: addresses 8000h–BFFFh select RAM when `page` is 0 or 1, and not for any other page.
- R5: Addresses C000h–FFFFh select RAM for every page, mode and variant while `mem_req` is 1.
- R6: Full variant: for pages 2 to 15 in either mode, and for any nonzero page with `ram_only`=1, only C000h–FFFFh selects RAM.
- R7: Half variant: `ram_sel` is 1 only for C000h–FFFFh, or for 8000h–BFFFh with `page`=0. `ram_only` has no effect on it.
- R8: `row_addr` is {A14, A6, A5, A4, A3, A2, A1, A0}, with bit 7 = A14 and bits 6:0 = A6:A0. It does not depend on `mem_req`, page, mode or variant.
- R9: `col_addr[6:0]` is A13:A7, so bit 0 = A7 and bit 6 = A13, in every variant.
- R10: Full variant: `col_addr[7]` equals A15, except that it is 0 when `ram_only`=0, `page`=1 and the address is in 8000h–BFFFh.
- R11: Half variant: `col_addr[7]` is the constant set by parameter `HALF_UPPER`, where 0 is the lower half and 1 is the upper half. It does not depend on the address, page or mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_req | input | 1 | Memory request active (high) |
| addr | input | 16 | CPU address A15:A0 |
| page | input | 4 | Current RAM page number |
| ram_only | input | 1 | 1 = RAM-only mode, 0 = ROM mode |
| ram_sel | output | 1 | Access targets on-board DRAM |
| row_addr | output | 8 | Row byte for the multiplexed DRAM |
| col_addr | output | 8 | Column byte for the multiplexed DRAM |

## Verification
The block has no state. A fault in the quarter decode, the page compare or the column mux therefore shows at the ports in the same cycle that the offending input is applied. A wrong quarter decode shows up as `ram_sel` disagreeing with the memory map in a whole 16 KB band. A broken page-1 remap shows up only as a wrong `col_addr[7]`, for ROM mode, page 1 and 8000h–BFFFh, so the stimulus must reach that narrow corner directly. A swapped address bit in the row or column byte shows up on any address where the two bits differ. Random addresses hit this quickly, while directed walking-ones patterns make it certain.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [1:0] {
    QTR_LOW    = 2'd0,
    QTR_LMID   = 2'd1,
    QTR_UMID   = 2'd2,
    QTR_COMMON = 2'd3
  } quarter_e;
endpackage

// File: rtl/dram_quarter_decode.sv
module dram_quarter_decode
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output quarter_e          quarter
);
  // the two top address bits name the 16 KB quarter
  assign quarter = quarter_e'(addr[ADDR_W-1 -: 2]);
endmodule

// File: rtl/dram_select_logic.sv
module dram_select_logic
  import dram_dec_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter bit FULL_CAP = 1'b1
) (
  input  logic              mem_req,
  input  quarter_e          quarter,
  input  logic [PAGE_W-1:0] page,
  input  logic              ram_only,
  output logic              hit
);
  localparam logic [PAGE_W-1:0] PAGE_ZERO = '0;
  localparam logic [PAGE_W-1:0] PAGE_ONE  = PAGE_W'(1);

  logic page_is0;
  logic page_is1;
  logic region_hit;

  assign page_is0 = (page == PAGE_ZERO);
  assign page_is1 = (page == PAGE_ONE);

  generate
    if (FULL_CAP) begin : g_full
      always_comb begin
        region_hit = 1'b0;
        if (ram_only) begin
          region_hit = page_is0 || (quarter == QTR_COMMON);
        end else begin
          unique case (quarter)
            QTR_LOW:    region_hit = 1'b0;
            QTR_LMID:   region_hit = page_is0;
            QTR_UMID:   region_hit = page_is0 || page_is1;
            QTR_COMMON: region_hit = 1'b1;
            default:    region_hit = 1'b0;
          endcase
        end
      end
    end else begin : g_half
      logic unused_mode_bits;
      assign unused_mode_bits = ram_only ^ page_is1;
      always_comb begin
        region_hit = (quarter == QTR_COMMON) ||
                     ((quarter == QTR_UMID) && page_is0);
      end
    end
  endgenerate

  assign hit = mem_req && region_hit;

  always_comb begin
    if (!mem_req)
      a_r1_idle_no_select: assert (!hit) else $error("R1: select without request");
    if (mem_req && quarter == QTR_COMMON)
      a_r5_common_always: assert (hit) else $error("R5: common quarter not selected");
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 4,
  parameter bit FULL_CAP   = 1'b1,
  parameter bit HALF_UPPER = 1'b0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  quarter_e            quarter,
  input  logic [PAGE_W-1:0]   page,
  input  logic                ram_only,
  output logic [ADDR_W/2-1:0] row_addr,
  output logic [ADDR_W/2-1:0] col_addr
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int LOW_W  = HALF_W - 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);

  logic col_msb;

  // row byte: low address bits plus the next-to-top address bit on top
  assign row_addr = {addr[ADDR_W-2], addr[LOW_W-1:0]};
  // column byte low bits: the middle of the address in ascending order
  assign col_addr[LOW_W-1:0] = addr[ADDR_W-3:LOW_W];

  generate
    if (FULL_CAP) begin : g_full
      logic remap;
      assign remap   = !ram_only && (page == PAGE_ONE) && (quarter == QTR_UMID);
      assign col_msb = remap ? 1'b0 : addr[ADDR_W-1];
    end else begin : g_half
      logic unused_half_bits;
      assign unused_half_bits = ^{addr[ADDR_W-1], quarter, page, ram_only};
      assign col_msb = HALF_UPPER;
    end
  endgenerate

  assign col_addr[HALF_W-1] = col_msb;
endmodule

// File: rtl/dram_page_decoder.sv
module dram_page_decoder
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 4,
  parameter bit FULL_CAP   = 1'b1,
  parameter bit HALF_UPPER = 1'b0
) (
  input  logic                mem_req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PAGE_W-1:0]   page,
  input  logic                ram_only,
  output logic                ram_sel,
  output logic [ADDR_W/2-1:0] row_addr,
  output logic [ADDR_W/2-1:0] col_addr
);
  localparam int HALF_W = ADDR_W / 2;
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);

  quarter_e quarter;

  dram_quarter_decode #(.ADDR_W(ADDR_W)) u_quarter (
    .addr    (addr),
    .quarter (quarter)
  );

  dram_select_logic #(.PAGE_W(PAGE_W), .FULL_CAP(FULL_CAP)) u_select (
    .mem_req  (mem_req),
    .quarter  (quarter),
    .page     (page),
    .ram_only (ram_only),
    .hit      (ram_sel)
  );

  dram_addr_mux #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .FULL_CAP(FULL_CAP), .HALF_UPPER(HALF_UPPER)
  ) u_mux (
    .addr     (addr),
    .quarter  (quarter),
    .page     (page),
    .ram_only (ram_only),
    .row_addr (row_addr),
    .col_addr (col_addr)
  );

  // cross-checks between the select path and the column path
  always_comb begin
    if (FULL_CAP && col_addr[HALF_W-1] != addr[ADDR_W-1])
      a_r10_remap_only_page1: assert (!ram_only && page == PAGE_ONE && quarter == QTR_UMID)
        else $error("R10: column MSB altered outside the remap window");
    if (FULL_CAP && ram_sel && !ram_only)
      a_r3_rom_low_blocked: assert (quarter != QTR_LOW)
        else $error("R3: low quarter selected in ROM mode");
    if (!FULL_CAP && ram_sel)
      a_r7_half_window: assert (quarter == QTR_COMMON || (quarter == QTR_UMID && page == '0))
        else $error("R7: half variant selected outside its window");
  end
endmodule

// File: tb/tb_dram_page_decoder.sv
module tb_dram_page_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        mem_req;
  logic [15:0] addr;
  logic [3:0]  page;
  logic        ram_only;

  logic       sel_f, sel_l, sel_h;
  logic [7:0] row_f, row_l, row_h, col_f, col_l, col_h;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dram_page_decoder #(.FULL_CAP(1'b1)) dut (
    .mem_req(mem_req), .addr(addr), .page(page), .ram_only(ram_only),
    .ram_sel(sel_f), .row_addr(row_f), .col_addr(col_f));
  dram_page_decoder #(.FULL_CAP(1'b0), .HALF_UPPER(1'b0)) dut_lo (
    .mem_req(mem_req), .addr(addr), .page(page), .ram_only(ram_only),
    .ram_sel(sel_l), .row_addr(row_l), .col_addr(col_l));
  dram_page_decoder #(.FULL_CAP(1'b0), .HALF_UPPER(1'b1)) dut_hi (
    .mem_req(mem_req), .addr(addr), .page(page), .ram_only(ram_only),
    .ram_sel(sel_h), .row_addr(row_h), .col_addr(col_h));

  function automatic bit exp_sel(bit full, bit rq, logic [15:0] a, logic [3:0] pg, bit ro);
    logic [1:0] q = a[15:14];
    if (!rq) return 1'b0;
    if (q == 2'd3) return 1'b1;
    if (!full) return (q == 2'd2) && (pg == 4'd0);
    if (ro) return pg == 4'd0;
    case (q)
      2'd1:    return pg == 4'd0;
      2'd2:    return pg <= 4'd1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string sel_tag(bit full, bit rq, logic [15:0] a, logic [3:0] pg, bit ro);
    if (!rq) return "R1";
    if (a[15:14] == 2'd3) return "R5";
    if (!full) return "R7";
    if (pg >= 4'd2 || (ro && pg != 4'd0)) return "R6";
    if (ro) return "R2";
    if (a[15:14] == 2'd2) return "R4";
    return "R3";
  endfunction

  function automatic logic [7:0] exp_row(logic [15:0] a);
    return {a[14], a[6:0]};
  endfunction

  function automatic logic [7:0] exp_col(bit full, bit upper, logic [15:0] a,
                                         logic [3:0] pg, bit ro);
    logic msb;
    if (!full) msb = upper;
    else if (!ro && pg == 4'd1 && a[15:14] == 2'd2) msb = 1'b0;
    else msb = a[15];
    return {msb, a[13:7]};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: addr=%h page=%0d ram_only=%0b req=%0b actual=%h expected=%h",
               tag, addr, page, ram_only, mem_req, act, exp);
    end
  endtask

  task automatic apply(bit rq, logic [15:0] a, logic [3:0] pg, bit ro);
    @(posedge clk);
    #1;
    mem_req = rq; addr = a; page = pg; ram_only = ro;
    @(negedge clk);
    chk(sel_tag(1, rq, a, pg, ro), {7'd0, sel_f}, {7'd0, exp_sel(1, rq, a, pg, ro)});
    chk(sel_tag(0, rq, a, pg, ro), {7'd0, sel_l}, {7'd0, exp_sel(0, rq, a, pg, ro)});
    chk(sel_tag(0, rq, a, pg, ro), {7'd0, sel_h}, {7'd0, exp_sel(0, rq, a, pg, ro)});
    chk("R8",  row_f, exp_row(a));
    chk("R8",  row_l, exp_row(a));
    chk("R10", col_f, exp_col(1, 0, a, pg, ro));  // R9 low bits and R10 MSB
    chk("R11", col_l, exp_col(0, 0, a, pg, ro));  // R9 low bits, R11 lower half
    chk("R11", col_h, exp_col(0, 1, a, pg, ro));  // R9 low bits, R11 upper half
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mem_req = 1'b0; addr = '0; page = '0; ram_only = 1'b0;
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    // idle state: no request, no select (R1)
    chk("R1", {7'd0, sel_f}, 8'd0);
    chk("R1", {7'd0, sel_l}, 8'd0);

    // directed corners: every quarter edge, pages 0,1,2,15, both modes, request on/off
    foreach (addr_list[i])
      for (int pg = 0; pg < 16; pg++)
        if (pg <= 2 || pg == 15)
          for (int m = 0; m < 2; m++)
            for (int rq = 0; rq < 2; rq++)
              apply(rq[0], addr_list[i], pg[3:0], m[0]);

    // walking ones for row/column bit positions (R8, R9)
    for (int b = 0; b < 16; b++) apply(1'b1, 16'h1 << b, 4'd0, 1'b1);

    // remap corner: page 1, ROM mode, 8000h-BFFFh (R10)
    apply(1'b1, 16'hA5A5, 4'd1, 1'b0);
    apply(1'b1, 16'hA5A5, 4'd1, 1'b1);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] pg;
      pg = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 2);
      apply(($urandom % 8) != 0, 16'($urandom), pg, 1'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [15:0] addr_list [8] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF,
                                 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
endmodule